// File: doc/BRIEF.md
# DAC Sample Feed Stage

This stage takes sample words from a DMA read stream and presents them to a converter-side device core. That core samples its data bus whenever it raises a request strobe. It has no qualifier of its own telling it whether the bus carries fresh data. The stage accepts one word from the stream for each request cycle and registers it onto the output bus. The valid and underflow indications pass through the same register, so they describe the word that is on the bus in that same cycle.

The core reads the bus blindly, so the stage keeps the bus in a defined state at all times:
- During gaps between requests it holds the most recent sample, so the core never sees a spurious zero in the middle of a transfer.
- After the word marked as the end of a transfer has been shown for one cycle, the bus returns to zero.
- The bus is also forced to zero while no transfer is active.

Each request that finds no word available raises a one-cycle underflow pulse. The same event also sets a sticky flag, which stays set until a dedicated clear input is used.

Top module: `dac_fifo_rd`

## Requirements
- R1: The sample width is the parameter DATA_W (default 32). Every bit of an accepted word, including the most significant, appears unchanged on `dev_data_o`.
- R2: `s_ready_o` is high in exactly those cycles where `dev_req_i` and `xfer_active_i` are both high. It follows these inputs within the same cycle.
- R3: A cycle with `s_valid_i && s_ready_o` accepts the word. In the next cycle `dev_data_o` equals that word and `out_valid_o` is high for that one cycle. Each accepted word appears exactly once.
- R4: While a transfer is active and no word is accepted, `dev_data_o` keeps its value. The only exception is the cycle after an end-of-transfer word, which R5 covers.
- R5: After a word accepted with `s_last_i` high has been shown for one cycle, `dev_data_o` becomes zero. This happens unless another word is accepted in that cycle, in which case the new word is shown.
- R6: In any cycle with `xfer_active_i` low, `dev_data_o` is zero in the following cycle.
- R7: Every cycle with `dev_req_i` high and no accepted word gives `underrun_o` high in the next cycle. This includes back-to-back requests and requests while inactive.
- R8: `out_valid_o` and `underrun_o` are never high together.
- R9: `underrun_sticky_o` rises together with `underrun_o` and stays high until `underrun_clr_i` is applied. If a clear and a new underflow fall in the same cycle, the flag stays set.
- R10: A synchronous active-high `rst` zeroes `dev_data_o`, `out_valid_o`, `underrun_o` and `underrun_sticky_o`, and clears the end-of-transfer state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| xfer_active_i | input | 1 | A DMA transfer is in progress |
| s_valid_i | input | 1 | Stream word available |
| s_data_i | input | DATA_W | Stream sample word |
| s_last_i | input | 1 | Word ends the transfer |
| s_ready_o | output | 1 | Stream word taken this cycle |
| dev_req_i | input | 1 | Device asks for a sample |
| dev_data_o | output | DATA_W | Registered sample bus |
| out_valid_o | output | 1 | Bus carries a newly taken word |
| underrun_o | output | 1 | One-cycle underflow pulse |
| underrun_sticky_o | output | 1 | Accumulated underflow flag |
| underrun_clr_i | input | 1 | Clears the accumulated flag |

## Verification
Two pairs of events can fall in the same cycle. A new underflow can coincide with a sticky-flag clear. A fresh end-of-transfer word can be accepted in the very cycle when the previous end marker would otherwise zero the bus.

The bench forces both pairs with directed sequences, then covers them again with random request, valid, last, active and clear patterns. A per-cycle reference model decides the expected outcome:
- When a clear meets a new underflow, the flag must stay set.
- When the zeroing cycle meets a new word, the new word must be shown rather than zero.

// File: rtl/dfrd_pkg.sv
package dfrd_pkg;

    typedef enum logic [1:0] {
        BUS_HOLD = 2'd0,
        BUS_LOAD = 2'd1,
        BUS_ZERO = 2'd2
    } bus_act_e;

    typedef struct packed {
        logic pulse;
        logic sticky;
    } stat_t;

endpackage

// File: rtl/dfrd_ctrl.sv
module dfrd_ctrl (
    input  logic active_i,
    input  logic valid_i,
    input  logic last_i,
    input  logic req_i,
    input  logic last_pend_i,
    output logic ready_o,
    output logic take_o,
    output logic starve_o,
    output logic take_last_o,
    output dfrd_pkg::bus_act_e act_o
);
    import dfrd_pkg::*;

    always_comb begin
        ready_o     = req_i && active_i;
        take_o      = ready_o && valid_i;
        starve_o    = req_i && !take_o;
        take_last_o = take_o && last_i;
        if (!active_i) begin
            act_o = BUS_ZERO;
        end else if (take_o) begin
            act_o = BUS_LOAD;
        end else if (last_pend_i) begin
            act_o = BUS_ZERO;
        end else begin
            act_o = BUS_HOLD;
        end
    end
endmodule

// File: rtl/dfrd_outreg.sv
module dfrd_outreg #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  dfrd_pkg::bus_act_e act_i,
    input  logic              take_last_i,
    input  logic [DATA_W-1:0] data_i,
    output logic [DATA_W-1:0] data_o,
    output logic              valid_o,
    output logic              last_pend_o
);
    import dfrd_pkg::*;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              valid;
        logic              last_pend;
    } oreg_t;

    oreg_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        case (act_i)
            BUS_LOAD: begin
                st_d.data      = data_i;
                st_d.valid     = 1'b1;
                st_d.last_pend = take_last_i;
            end
            BUS_ZERO: begin
                st_d.data      = '0;
                st_d.last_pend = 1'b0;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign data_o      = st_q.data;
    assign valid_o     = st_q.valid;
    assign last_pend_o = st_q.last_pend;
endmodule

// File: rtl/dfrd_status.sv
module dfrd_status (
    input  logic clk,
    input  logic rst,
    input  logic starve_i,
    input  logic clr_i,
    output logic pulse_o,
    output logic sticky_o
);
    import dfrd_pkg::*;

    stat_t st_d, st_q;

    always_comb begin
        st_d.pulse  = starve_i;
        st_d.sticky = (st_q.sticky && !clr_i) || starve_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pulse_o  = st_q.pulse;
    assign sticky_o = st_q.sticky;
endmodule

// File: rtl/dac_fifo_rd.sv
module dac_fifo_rd #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              xfer_active_i,
    input  logic              s_valid_i,
    input  logic [DATA_W-1:0] s_data_i,
    input  logic              s_last_i,
    output logic              s_ready_o,
    input  logic              dev_req_i,
    output logic [DATA_W-1:0] dev_data_o,
    output logic              out_valid_o,
    output logic              underrun_o,
    output logic              underrun_sticky_o,
    input  logic              underrun_clr_i
);
    import dfrd_pkg::*;

    logic     take;
    logic     starve;
    logic     take_last;
    logic     last_pend;
    bus_act_e act;

    dfrd_ctrl u_ctrl (
        .active_i    (xfer_active_i),
        .valid_i     (s_valid_i),
        .last_i      (s_last_i),
        .req_i       (dev_req_i),
        .last_pend_i (last_pend),
        .ready_o     (s_ready_o),
        .take_o      (take),
        .starve_o    (starve),
        .take_last_o (take_last),
        .act_o       (act)
    );

    dfrd_outreg #(.DATA_W(DATA_W)) u_outreg (
        .clk         (clk),
        .rst         (rst),
        .act_i       (act),
        .take_last_i (take_last),
        .data_i      (s_data_i),
        .data_o      (dev_data_o),
        .valid_o     (out_valid_o),
        .last_pend_o (last_pend)
    );

    dfrd_status u_status (
        .clk      (clk),
        .rst      (rst),
        .starve_i (starve),
        .clr_i    (underrun_clr_i),
        .pulse_o  (underrun_o),
        .sticky_o (underrun_sticky_o)
    );
endmodule

// File: rtl/dfrd_chk.sv
module dfrd_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              xfer_active_i,
    input logic              s_valid_i,
    input logic [DATA_W-1:0] s_data_i,
    input logic              s_ready_o,
    input logic              dev_req_i,
    input logic [DATA_W-1:0] dev_data_o,
    input logic              out_valid_o,
    input logic              underrun_o,
    input logic              underrun_sticky_o,
    input logic              underrun_clr_i,
    input logic              last_pend
);
    // R3: an accepted word is on the bus, marked valid, one cycle later
    a_r3_word_lands: assert property (@(posedge clk) disable iff (rst)
        (s_valid_i && s_ready_o) |=> (out_valid_o && dev_data_o == $past(s_data_i)));

    // R4: with no acceptance and no pending end marker the bus is stable
    a_r4_hold_gap: assert property (@(posedge clk) disable iff (rst)
        (xfer_active_i && !(s_valid_i && s_ready_o) && !last_pend) |=> $stable(dev_data_o));

    // R6: an inactive cycle leaves zero on the bus
    a_r6_idle_zero: assert property (@(posedge clk) disable iff (rst)
        !xfer_active_i |=> (dev_data_o == '0));

    // R7: a request without a word produces an underflow pulse
    a_r7_starve_flag: assert property (@(posedge clk) disable iff (rst)
        (dev_req_i && !(s_valid_i && s_ready_o)) |=> underrun_o);

    // R8: valid and underflow never coincide
    a_r8_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(out_valid_o && underrun_o));

    // R9: the sticky flag covers every pulse and only falls on a clear
    a_r9_sticky_cover: assert property (@(posedge clk) disable iff (rst)
        underrun_o |-> underrun_sticky_o);
    a_r9_sticky_fall: assert property (@(posedge clk) disable iff (rst)
        $fell(underrun_sticky_o) |-> $past(underrun_clr_i));

    // R2: ready never without a request
    a_r2_ready_req: assert property (@(posedge clk) disable iff (rst)
        s_ready_o |-> dev_req_i);
endmodule

bind dac_fifo_rd dfrd_chk #(.DATA_W(DATA_W)) u_dfrd_chk (
    .clk               (clk),
    .rst               (rst),
    .xfer_active_i     (xfer_active_i),
    .s_valid_i         (s_valid_i),
    .s_data_i          (s_data_i),
    .s_ready_o         (s_ready_o),
    .dev_req_i         (dev_req_i),
    .dev_data_o        (dev_data_o),
    .out_valid_o       (out_valid_o),
    .underrun_o        (underrun_o),
    .underrun_sticky_o (underrun_sticky_o),
    .underrun_clr_i    (underrun_clr_i),
    .last_pend         (last_pend)
);

// File: tb/test_dac_fifo_rd.sv
module test_dac_fifo_rd;
    localparam int DATA_W = 32;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              act = 1'b0, vld = 1'b0, lst = 1'b0, req = 1'b0, clr = 1'b0;
    logic [DATA_W-1:0] din = '0;
    logic              rdy, ovld, und, stk;
    logic [DATA_W-1:0] dout;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    // reference model state
    logic [DATA_W-1:0] m_data = '0;
    logic m_vld = 0, m_und = 0, m_stk = 0, m_lp = 0;
    string m_tag = "R10";

    always #4 clk = ~clk;

    dac_fifo_rd #(.DATA_W(DATA_W)) i_dac_fifo_rd (
        .clk(clk), .rst(rst), .xfer_active_i(act), .s_valid_i(vld),
        .s_data_i(din), .s_last_i(lst), .s_ready_o(rdy), .dev_req_i(req),
        .dev_data_o(dout), .out_valid_o(ovld), .underrun_o(und),
        .underrun_sticky_o(stk), .underrun_clr_i(clr)
    );

    task automatic chk(input string tag, input logic [DATA_W-1:0] got, input logic [DATA_W-1:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
        end
    endtask

    function automatic logic exp_ready(input logic r, input logic a);
        return r && a;
    endfunction

    // advance the model by one clock using the inputs now applied
    task automatic model_step();
        logic take;
        take = exp_ready(req, act) && vld;
        if (rst) begin
            m_data = '0; m_vld = 0; m_und = 0; m_stk = 0; m_lp = 0; m_tag = "R10";
        end else begin
            m_und = req && !take;
            m_stk = (m_stk && !clr) || m_und;
            m_vld = take;
            if (!act) begin
                m_data = '0; m_lp = 0; m_tag = "R6";
            end else if (take) begin
                m_data = din; m_lp = lst; m_tag = "R3/R1";
            end else if (m_lp) begin
                m_data = '0; m_lp = 0; m_tag = "R5";
            end else begin
                m_tag = "R4";
            end
        end
    endtask

    // one cycle: check outputs, apply inputs, check ready, update model
    task automatic cyc(input logic a, input logic v, input logic l, input logic r,
                       input logic c, input logic [DATA_W-1:0] d);
        @(negedge clk);
        chk(m_tag, dout, m_data);
        chk("R3 valid", {{(DATA_W-1){1'b0}}, ovld}, {{(DATA_W-1){1'b0}}, m_vld});
        chk("R7 pulse", {{(DATA_W-1){1'b0}}, und}, {{(DATA_W-1){1'b0}}, m_und});
        chk("R9 sticky", {{(DATA_W-1){1'b0}}, stk}, {{(DATA_W-1){1'b0}}, m_stk});
        if (!rst) chk("R8 excl", {{(DATA_W-1){1'b0}}, ovld && und}, '0);
        act = a; vld = v; lst = l; req = r; clr = c; din = d;
        #1;
        chk("R2 ready", {{(DATA_W-1){1'b0}}, rdy}, {{(DATA_W-1){1'b0}}, exp_ready(r, a)});
        model_step();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        // R10 reset
        rst = 1'b1;
        cyc(1, 1, 0, 1, 0, 32'hDEAD_BEEF);
        cyc(1, 1, 0, 1, 0, 32'hDEAD_BEEF);
        @(negedge clk); rst = 1'b0; model_step();
        // R3 R1 single word with top bit set, R4 gap of several cycles
        cyc(1, 1, 0, 1, 0, 32'h8000_0001);
        cyc(1, 1, 0, 0, 0, 32'h1111_1111);
        cyc(1, 0, 0, 0, 0, 32'h2222_2222);
        cyc(1, 0, 0, 0, 0, 32'h3333_3333);
        // R7 back-to-back underflows, R9 clear coinciding with new underflow
        cyc(1, 0, 0, 1, 0, 32'h0);
        cyc(1, 0, 0, 1, 0, 32'h0);
        cyc(1, 0, 0, 1, 1, 32'h0);
        cyc(1, 0, 0, 0, 1, 32'h0);
        cyc(1, 0, 0, 0, 0, 32'h0);
        // R5 end marker, then new word accepted in the zeroing cycle
        cyc(1, 1, 1, 1, 0, 32'hAAAA_5555);
        cyc(1, 1, 1, 1, 0, 32'h5555_AAAA);
        cyc(1, 0, 0, 0, 0, 32'h0);
        cyc(1, 0, 0, 0, 0, 32'h0);
        // R6 inactive forces zero, request while inactive underflows
        cyc(1, 1, 0, 1, 0, 32'h1234_5678);
        cyc(0, 1, 0, 1, 0, 32'h9999_9999);
        cyc(0, 0, 0, 0, 0, 32'h0);
        // random mix
        for (int i = 0; i < 3000; i++) begin
            cyc(($urandom % 8) != 0, ($urandom % 3) != 0, ($urandom % 6) == 0,
                ($urandom % 2) == 0, ($urandom % 10) == 0, $urandom);
        end
        @(negedge clk);
        chk(m_tag, dout, m_data);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule